// File: doc/BRIEF.md
# Interrupt redirection table controller

This block routes up to two dozen external interrupt lines to a processor-side message sink. Software programs it through two memory-mapped locations. The first is a select location that holds a register index. The second is a 32-bit data window that reads or writes whichever register the index names. The block holds an identification register and one 64-bit routing entry per input line. Each entry carries the vector to send, the delivery mode, whether the destination is a single target ID or a target mask, the input polarity, edge or level detection, and a mask bit.

On every clock the block samples its input lines and applies each entry's polarity and detection mode. A detected request becomes pending and shows as a read-only status bit in its entry. Pending requests are offered one at a time on a valid/ready message port, and the lowest line number goes first. A level-detected request also sets a read-only "in service" bit when the sink takes it. That bit blocks further messages from the line until an end-of-interrupt input arrives carrying the same vector.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, every entry's low word reads 0x0001_0000 (masked, vector 0, all other fields 0), its high word reads 0, the select location reads 0 and `msg_valid` is 0.
- R2: A write at byte offset 0x00 loads the register index, and offset 0x10 accesses the selected register. Entry n's low word is index 0x10+2n and its high word is index 0x11+2n. Low-word fields: vector [7:0], delivery mode [10:8], destination-is-mask [11], status [12], active-low [13], in-service [14], level [15], mask [16]. The high word holds the destination in bits [31:24].
- R3: Index 0x00 is the identification register. Only bits [27:24] are stored, and every other bit reads 0.
- R4: Bits [12] and [14] of the low word, and every unassigned bit, ignore writes. Indices with no register behind them read 0. Writing delivery-mode code 3 or 6 (reserved) leaves the stored mode unchanged.
- R5: With polarity 0 a line is active high, and with polarity 1 it is active low. In edge mode (bit 15 = 0), each inactive-to-active transition produces exactly one message, and holding the line active produces no more.
- R6: A masked entry never launches a message. An active transition that occurs while the entry is masked is dropped, and unmasking later does not produce a message for it.
- R7: The status bit reads 1 from the detection of a request until the sink accepts its message, and 0 afterwards.
- R8: A message stays on the port with unchanged fields while `msg_valid` is high and `msg_ready` is low. It carries the entry's vector, delivery mode, destination-is-mask bit, destination and line number.
- R9: A level entry (bit 15 = 1) whose line is active and unmasked sends a message. On acceptance the in-service bit is set, and no further message comes from that entry until `eoi_valid` arrives with a matching `eoi_vector`. A non-matching vector leaves the bit set.
- R10: Entries with delivery mode 4, 5 or 7 behave as edge-triggered and never set the in-service bit, whatever bit 15 holds.
- R11: An entry with delivery mode 2 sends vector 0, whatever vector is programmed.
- R12: When several entries are pending at once, messages leave in ascending line order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access (0x00 select, 0x10 window) |
| bus_wr_en | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| irq_pins | input | NUM_PINS | External interrupt lines |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being retired by the end-of-interrupt |
| msg_valid | output | 1 | Message offered to the sink |
| msg_ready | input | 1 | Sink accepts the message |
| msg_vector | output | 8 | Vector of the message |
| msg_dmode | output | 3 | Delivery mode of the message |
| msg_dest_logical | output | 1 | Destination is a target mask rather than an ID |
| msg_dest | output | 8 | Destination ID or mask |
| msg_pin | output | PIN_W | Input line that raised the message |

## Verification
The bench targets the places where a router like this tends to go wrong. An edge that arrives while the entry is masked must not come back as a message when the entry is later unmasked. A level line that stays high must send exactly once until the matching end-of-interrupt, so a design that ignored the in-service bit would flood the sink, and one that compared the vector carelessly would release on the wrong end-of-interrupt. The forced-edge delivery modes and the zeroed vector of mode 2 are driven with the level bit set, so a design that applied bit 15 blindly would set the in-service bit or repeat the message. Writes of the reserved mode codes, writes to the read-only bits and reads of empty indices are checked to catch a register file that stores everything. Two lines raised in the same cycle expose a wrong priority order.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // Byte offsets of the two software-visible locations
  localparam int unsigned SEL_OFS = 'h00;
  localparam int unsigned WIN_OFS = 'h10;

  // Register indices behind the window
  localparam logic [7:0] ID_IDX   = 8'h00;
  localparam logic [7:0] TBL_BASE = 8'h10;

  // Delivery mode codes that change behaviour
  localparam logic [2:0] DM_SMI  = 3'd2;
  localparam logic [2:0] DM_NMI  = 3'd4;
  localparam logic [2:0] DM_INIT = 3'd5;
  localparam logic [2:0] DM_EXT  = 3'd7;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       level;
    logic       act_low;
    logic       dest_mask;
    logic [2:0] dmode;
    logic [7:0] vector;
  } entry_cfg_t;

  localparam entry_cfg_t CFG_RESET = '{dest: 8'h00, mask: 1'b1, level: 1'b0,
                                       act_low: 1'b0, dest_mask: 1'b0,
                                       dmode: 3'd0, vector: 8'h00};

  function automatic logic dmode_reserved(input logic [2:0] m);
    return (m == 3'd3) || (m == 3'd6);
  endfunction

  function automatic logic dmode_forces_edge(input logic [2:0] m);
    return (m == DM_NMI) || (m == DM_INIT) || (m == DM_EXT);
  endfunction

  // Vector actually placed on the message port
  function automatic logic [7:0] sent_vector(input entry_cfg_t c);
    return (c.dmode == DM_SMI) ? 8'h00 : c.vector;
  endfunction

  // Apply a software write of the low word; read-only bits untouched
  function automatic entry_cfg_t cfg_write_lo(input entry_cfg_t old, input logic [31:0] w);
    entry_cfg_t n;
    n           = old;
    n.vector    = w[7:0];
    if (!dmode_reserved(w[10:8])) n.dmode = w[10:8];
    n.dest_mask = w[11];
    n.act_low   = w[13];
    n.level     = w[15];
    n.mask      = w[16];
    return n;
  endfunction

  function automatic logic [31:0] cfg_read_lo(input entry_cfg_t c, input logic st,
                                             input logic insvc);
    return {15'b0, c.mask, c.level, insvc, c.act_low, st, c.dest_mask, c.dmode, c.vector};
  endfunction

  function automatic logic [31:0] cfg_read_hi(input entry_cfg_t c);
    return {c.dest, 24'b0};
  endfunction

endpackage

// File: rtl/irq_reg_access.sv
module irq_reg_access
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int ADDR_W   = 8,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr_en,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  input  logic [NUM_PINS-1:0]         status_vec,
  input  logic [NUM_PINS-1:0]         insvc_vec,
  output entry_cfg_t [NUM_PINS-1:0]   cfg_o
);

  localparam logic [7:0] TBL_END = 8'(int'(TBL_BASE) + 2 * NUM_PINS);

  logic [7:0]                 sel_q;
  logic [3:0]                 id_q;
  entry_cfg_t [NUM_PINS-1:0]  cfg_q;

  logic                       at_sel, at_win;
  logic                       id_hit, tbl_hit, tbl_hi;
  logic [7:0]                 tbl_off;
  logic [PIN_W-1:0]           tbl_ent;
  logic                       win_wr;
  logic [31:0]                win_rdata;

  assign at_sel  = (bus_addr == ADDR_W'(SEL_OFS));
  assign at_win  = (bus_addr == ADDR_W'(WIN_OFS));
  assign id_hit  = (sel_q == ID_IDX);
  assign tbl_hit = (sel_q >= TBL_BASE) && (sel_q < TBL_END);
  assign tbl_off = sel_q - TBL_BASE;
  assign tbl_ent = tbl_off[PIN_W:1];
  assign tbl_hi  = tbl_off[0];
  assign win_wr  = bus_wr_en && at_win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 8'h00;
      id_q  <= 4'h0;
    end else begin
      if (bus_wr_en && at_sel) sel_q <= bus_wdata[7:0];
      if (win_wr && id_hit)    id_q  <= bus_wdata[27:24];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PINS; i++) cfg_q[i] <= CFG_RESET;
    end else if (win_wr && tbl_hit) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (tbl_ent == PIN_W'(i)) begin
          if (tbl_hi) cfg_q[i].dest <= bus_wdata[31:24];
          else        cfg_q[i]      <= cfg_write_lo(cfg_q[i], bus_wdata);
        end
      end
    end
  end

  always_comb begin
    win_rdata = 32'h0;
    if (id_hit) begin
      win_rdata = {4'h0, id_q, 24'h0};
    end else if (tbl_hit) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (tbl_ent == PIN_W'(i)) begin
          win_rdata = tbl_hi ? cfg_read_hi(cfg_q[i])
                             : cfg_read_lo(cfg_q[i], status_vec[i], insvc_vec[i]);
        end
      end
    end
  end

  always_comb begin
    if (at_sel)      bus_rdata = {24'h0, sel_q};
    else if (at_win) bus_rdata = win_rdata;
    else             bus_rdata = 32'h0;
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/irq_pin_detect.sv
module irq_pin_detect
  import irq_route_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pin_i,
  input  entry_cfg_t  cfg_i,
  input  logic        take_i,
  input  logic        eoi_valid_i,
  input  logic [7:0]  eoi_vector_i,
  output logic        pending_o,
  output logic        insvc_o,
  output logic        eligible_o
);

  logic act, act_q;
  logic edge_mode;
  logic edge_hit, level_hit, eoi_hit;
  logic pending_q, insvc_q;

  assign act       = pin_i ^ cfg_i.act_low;
  assign edge_mode = !cfg_i.level || dmode_forces_edge(cfg_i.dmode);
  assign edge_hit  = edge_mode && act && !act_q && !cfg_i.mask;
  assign level_hit = !edge_mode && act && !cfg_i.mask && !insvc_q;
  assign eoi_hit   = eoi_valid_i && (eoi_vector_i == cfg_i.vector);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      pending_q <= 1'b0;
      insvc_q   <= 1'b0;
    end else begin
      act_q <= act;
      if (take_i)                      pending_q <= edge_hit;
      else if (edge_hit || level_hit)  pending_q <= 1'b1;
      if (take_i && !edge_mode)        insvc_q   <= 1'b1;
      else if (eoi_hit)                insvc_q   <= 1'b0;
    end
  end

  assign pending_o  = pending_q;
  assign insvc_o    = insvc_q;
  assign eligible_o = pending_q && !cfg_i.mask;

endmodule

// File: rtl/irq_msg_issue.sv
module irq_msg_issue
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PINS-1:0]        eligible_vec,
  input  entry_cfg_t [NUM_PINS-1:0]  cfg_i,
  input  logic                       msg_ready,
  output logic                       msg_valid,
  output logic [7:0]                 msg_vector,
  output logic [2:0]                 msg_dmode,
  output logic                       msg_dest_logical,
  output logic [7:0]                 msg_dest,
  output logic [PIN_W-1:0]           msg_pin,
  output logic [NUM_PINS-1:0]        take_vec,
  output logic                       launch_fire,
  output logic [PIN_W-1:0]           launch_idx
);

  logic             busy_q;
  logic [PIN_W-1:0] cur_q;
  logic [7:0]       vec_q, dest_q;
  logic [2:0]       dmode_q;
  logic             dlog_q;
  logic             pick_any;
  logic [PIN_W-1:0] pick_idx;
  logic             accept;
  entry_cfg_t       pick_cfg;

  // Lowest-numbered eligible line wins
  always_comb begin
    pick_any = 1'b0;
    pick_idx = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (eligible_vec[i]) begin
        pick_any = 1'b1;
        pick_idx = PIN_W'(i);
      end
    end
  end

  always_comb begin
    pick_cfg = cfg_i[0];
    for (int i = 0; i < NUM_PINS; i++)
      if (pick_idx == PIN_W'(i)) pick_cfg = cfg_i[i];
  end

  assign launch_fire = pick_any && !busy_q;
  assign launch_idx  = pick_idx;
  assign accept      = busy_q && msg_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cur_q   <= '0;
      vec_q   <= 8'h0;
      dest_q  <= 8'h0;
      dmode_q <= 3'd0;
      dlog_q  <= 1'b0;
    end else if (launch_fire) begin
      busy_q  <= 1'b1;
      cur_q   <= pick_idx;
      vec_q   <= sent_vector(pick_cfg);
      dest_q  <= pick_cfg.dest;
      dmode_q <= pick_cfg.dmode;
      dlog_q  <= pick_cfg.dest_mask;
    end else if (accept) begin
      busy_q  <= 1'b0;
    end
  end

  generate
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_take
      assign take_vec[g] = accept && (cur_q == PIN_W'(g));
    end
  endgenerate

  assign msg_valid        = busy_q;
  assign msg_vector       = vec_q;
  assign msg_dmode        = dmode_q;
  assign msg_dest_logical = dlog_q;
  assign msg_dest         = dest_q;
  assign msg_pin          = cur_q;

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int ADDR_W   = 8,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr_en,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_PINS-1:0]  irq_pins,
  input  logic                 eoi_valid,
  input  logic [7:0]           eoi_vector,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [7:0]           msg_vector,
  output logic [2:0]           msg_dmode,
  output logic                 msg_dest_logical,
  output logic [7:0]           msg_dest,
  output logic [PIN_W-1:0]     msg_pin
);

  entry_cfg_t [NUM_PINS-1:0] cfg;
  logic [NUM_PINS-1:0]       status_vec;
  logic [NUM_PINS-1:0]       insvc_vec;
  logic [NUM_PINS-1:0]       eligible_vec;
  logic [NUM_PINS-1:0]       take_vec;
  logic [NUM_PINS-1:0]       mask_vec;
  logic                      launch_fire;
  logic [PIN_W-1:0]          launch_idx;

  irq_reg_access #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr_en  (bus_wr_en),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .status_vec (status_vec),
    .insvc_vec  (insvc_vec),
    .cfg_o      (cfg)
  );

  generate
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
      irq_pin_detect u_det (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_i        (irq_pins[g]),
        .cfg_i        (cfg[g]),
        .take_i       (take_vec[g]),
        .eoi_valid_i  (eoi_valid),
        .eoi_vector_i (eoi_vector),
        .pending_o    (status_vec[g]),
        .insvc_o      (insvc_vec[g]),
        .eligible_o   (eligible_vec[g])
      );
      assign mask_vec[g] = cfg[g].mask;
    end
  endgenerate

  irq_msg_issue #(.NUM_PINS(NUM_PINS)) u_issue (
    .clk              (clk),
    .rst_n            (rst_n),
    .eligible_vec     (eligible_vec),
    .cfg_i            (cfg),
    .msg_ready        (msg_ready),
    .msg_valid        (msg_valid),
    .msg_vector       (msg_vector),
    .msg_dmode        (msg_dmode),
    .msg_dest_logical (msg_dest_logical),
    .msg_dest         (msg_dest),
    .msg_pin          (msg_pin),
    .take_vec         (take_vec),
    .launch_fire      (launch_fire),
    .launch_idx       (launch_idx)
  );

endmodule

// File: rtl/irq_route_checks.sv
module irq_route_checks #(
  parameter int NUM_PINS = 24,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 msg_valid,
  input logic                 msg_ready,
  input logic [7:0]           msg_vector,
  input logic [2:0]           msg_dmode,
  input logic [7:0]           msg_dest,
  input logic [PIN_W-1:0]     msg_pin,
  input logic                 launch_fire,
  input logic [PIN_W-1:0]     launch_idx,
  input logic [NUM_PINS-1:0]  mask_vec,
  input logic [NUM_PINS-1:0]  insvc_vec,
  input logic [NUM_PINS-1:0]  status_vec
);

  // R8: an offered message is held unchanged until taken
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_pin)
                                && $stable(msg_dest) && $stable(msg_dmode));

  // R11: mode 2 always carries vector 0
  assert_smi_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && (msg_dmode == 3'd2) |-> msg_vector == 8'h00);

  // R6: the issuer never starts a message for a masked entry
  assert_mask_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    launch_fire |-> !mask_vec[launch_idx]);

  // R9: no launch from an entry whose in-service bit is set
  assert_insvc_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    launch_fire |-> !insvc_vec[launch_idx]);

  // R7: the line on the port still reports its status bit
  assert_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> status_vec[msg_pin]);

endmodule

bind irq_route_ctrl irq_route_checks #(.NUM_PINS(NUM_PINS)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .msg_valid   (msg_valid),
  .msg_ready   (msg_ready),
  .msg_vector  (msg_vector),
  .msg_dmode   (msg_dmode),
  .msg_dest    (msg_dest),
  .msg_pin     (msg_pin),
  .launch_fire (launch_fire),
  .launch_idx  (launch_idx),
  .mask_vec    (mask_vec),
  .insvc_vec   (insvc_vec),
  .status_vec  (status_vec)
);

// File: tb/test_irq_route_ctrl.sv
`timescale 1ns/1ps
module test_irq_route_ctrl;

  localparam int NP = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] irq_pins = '0;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vector = 8'h0;
  logic        msg_valid, msg_ready = 1'b0;
  logic [7:0]  msg_vector, msg_dest;
  logic [2:0]  msg_dmode;
  logic        msg_dest_logical;
  logic [4:0]  msg_pin;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_route_ctrl i_irq_route_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pins(irq_pins),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dmode(msg_dmode),
    .msg_dest_logical(msg_dest_logical), .msg_dest(msg_dest), .msg_pin(msg_pin)
  );

  logic [31:0] m_lo [NP];
  logic [31:0] m_hi [NP];

  function automatic logic [31:0] pack_lo(logic [7:0] vec, logic [2:0] dm, logic dl,
      logic pol, logic lvl, logic msk, logic st, logic busy);
    return (32'(msk) << 16) | (32'(lvl) << 15) | (32'(busy) << 14) | (32'(pol) << 13)
         | (32'(st) << 12) | (32'(dl) << 11) | (32'(dm) << 8) | 32'(vec);
  endfunction

  function automatic logic [31:0] model_lo(logic [31:0] old, logic [31:0] w);
    logic [31:0] n;
    n = w & 32'h0001_AFFF;
    if (w[10:8] == 3'd3 || w[10:8] == 3'd6) n = (n & ~32'h700) | (old & 32'h700);
    return n;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [31:0] d);
    bus_write(8'h00, 32'(idx));
    bus_write(8'h10, d);
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [31:0] d);
    bus_write(8'h00, 32'(idx));
    bus_addr = 8'h10;
    #1 d = bus_rdata;
  endtask

  task automatic cfg_entry(input int p, input logic [7:0] vec, input logic [2:0] dm,
      input logic dl, input logic pol, input logic lvl, input logic msk, input logic [7:0] dest);
    reg_write(8'(16 + 2 * p), pack_lo(vec, dm, dl, pol, lvl, msk, 1'b0, 1'b0));
    reg_write(8'(17 + 2 * p), {dest, 24'h0});
  endtask

  task automatic wait_msg(input int lim, output bit got);
    got = 0;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      if (msg_valid) begin got = 1; break; end
    end
  endtask

  task automatic accept_msg();
    @(negedge clk);
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic send_eoi(input logic [7:0] v);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic set_pin(input int p, input logic v);
    @(negedge clk);
    irq_pins[p] = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] w;
    bit got;
    int ent;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    #1 chk("R1 msg_valid", 32'(msg_valid), 32'h0);
    chk("R1 select", bus_rdata, 32'h0);
    for (int p = 0; p < NP; p += 7) begin
      reg_read(8'(16 + 2 * p), rd); chk("R1 entry low", rd, 32'h0001_0000);
      reg_read(8'(17 + 2 * p), rd); chk("R1 entry high", rd, 32'h0);
    end
    for (int p = 0; p < NP; p++) begin m_lo[p] = 32'h0001_0000; m_hi[p] = 32'h0; end

    // R3: identification register
    reg_write(8'h00, 32'hFFFF_FFFF);
    reg_read(8'h00, rd); chk("R3 id field", rd, 32'h0F00_0000);
    bus_write(8'h00, 32'h0000_0000);
    bus_addr = 8'h00;
    #1 chk("R2 select readback", bus_rdata, 32'h0);

    // R2/R4: random programming of the table, masked so no line fires
    for (int it = 0; it < 40; it++) begin
      ent = int'($urandom_range(NP - 1));
      w = $urandom() | 32'h0001_0000;
      if ($urandom_range(1) == 1) begin
        reg_write(8'(16 + 2 * ent), w);
        m_lo[ent] = model_lo(m_lo[ent], w);
      end else begin
        reg_write(8'(17 + 2 * ent), w);
        m_hi[ent] = w & 32'hFF00_0000;
      end
      reg_read(8'(16 + 2 * ent), rd); chk("R2 R4 random low word", rd, m_lo[ent]);
      reg_read(8'(17 + 2 * ent), rd); chk("R2 random high word", rd, m_hi[ent]);
    end

    // R4: reserved mode codes, read-only bits, empty indices
    reg_write(8'h12, pack_lo(8'h10, 3'd1, 0, 0, 0, 1, 0, 0));
    reg_write(8'h12, pack_lo(8'h10, 3'd3, 0, 0, 0, 1, 1, 1));
    reg_read(8'h12, rd); chk("R4 reserved mode 3 and ro bits", rd, 32'h0001_0110);
    reg_write(8'h12, pack_lo(8'h10, 3'd6, 0, 0, 0, 1, 0, 0));
    reg_read(8'h12, rd); chk("R4 reserved mode 6", rd, 32'h0001_0110);
    reg_read(8'h40, rd); chk("R4 empty index 0x40", rd, 32'h0);
    reg_read(8'h05, rd); chk("R4 empty index 0x05", rd, 32'h0);

    // R5/R7/R8: edge, active high
    cfg_entry(3, 8'h41, 3'd0, 0, 0, 0, 0, 8'h22);
    set_pin(3, 1'b1);
    wait_msg(8, got); chk("R5 edge message", 32'(got), 32'h1);
    chk("R8 vector", 32'(msg_vector), 32'h41);
    chk("R8 dest", 32'(msg_dest), 32'h22);
    chk("R8 pin", 32'(msg_pin), 32'd3);
    repeat (3) @(negedge clk);
    chk("R8 held vector", 32'(msg_valid ? msg_vector : 8'h00), 32'h41);
    reg_read(8'h16, rd); chk("R7 status pending", rd, pack_lo(8'h41, 0, 0, 0, 0, 0, 1, 0));
    accept_msg();
    reg_read(8'h16, rd); chk("R7 status cleared", rd, pack_lo(8'h41, 0, 0, 0, 0, 0, 0, 0));
    wait_msg(10, got); chk("R5 single message while held", 32'(got), 32'h0);
    set_pin(3, 1'b0);

    // R5: active low
    set_pin(5, 1'b1);
    cfg_entry(5, 8'h52, 3'd0, 1, 1, 0, 0, 8'h0F);
    wait_msg(6, got); chk("R5 inactive level low-polarity", 32'(got), 32'h0);
    set_pin(5, 1'b0);
    wait_msg(8, got); chk("R5 active-low message", 32'(got), 32'h1);
    chk("R8 dest mask flag", 32'(msg_dest_logical), 32'h1);
    accept_msg();

    // R6: edge while masked is dropped
    cfg_entry(7, 8'h60, 3'd0, 0, 0, 0, 1, 8'h01);
    set_pin(7, 1'b1);
    wait_msg(10, got); chk("R6 masked no message", 32'(got), 32'h0);
    cfg_entry(7, 8'h60, 3'd0, 0, 0, 0, 0, 8'h01);
    wait_msg(10, got); chk("R6 no replay after unmask", 32'(got), 32'h0);
    set_pin(7, 1'b0);

    // R9: level with in-service gating
    cfg_entry(9, 8'h55, 3'd0, 0, 0, 1, 0, 8'h03);
    set_pin(9, 1'b1);
    wait_msg(8, got); chk("R9 level message", 32'(got), 32'h1);
    chk("R9 vector", 32'(msg_vector), 32'h55);
    accept_msg();
    reg_read(8'h22, rd); chk("R9 in-service set", rd, pack_lo(8'h55, 0, 0, 0, 1, 0, 0, 1));
    wait_msg(8, got); chk("R9 blocked until eoi", 32'(got), 32'h0);
    send_eoi(8'h56);
    wait_msg(6, got); chk("R9 wrong eoi keeps block", 32'(got), 32'h0);
    send_eoi(8'h55);
    wait_msg(8, got); chk("R9 resend after eoi", 32'(got), 32'h1);
    accept_msg();
    set_pin(9, 1'b0);
    send_eoi(8'h55);
    wait_msg(6, got); chk("R9 inactive after eoi", 32'(got), 32'h0);
    cfg_entry(9, 8'h55, 3'd0, 0, 0, 1, 1, 8'h03);

    // R10: forced edge for mode 4 with level bit set
    cfg_entry(11, 8'h02, 3'd4, 0, 0, 1, 0, 8'h04);
    set_pin(11, 1'b1);
    wait_msg(8, got); chk("R10 nmi message", 32'(got), 32'h1);
    chk("R10 mode", 32'(msg_dmode), 32'd4);
    accept_msg();
    wait_msg(8, got); chk("R10 only one message", 32'(got), 32'h0);
    reg_read(8'h26, rd); chk("R10 no in-service", rd, pack_lo(8'h02, 3'd4, 0, 0, 1, 0, 0, 0));
    set_pin(11, 1'b0);

    // R11: mode 2 zeroes the vector
    cfg_entry(13, 8'h77, 3'd2, 0, 0, 1, 0, 8'h05);
    set_pin(13, 1'b1);
    wait_msg(8, got); chk("R11 smi message", 32'(got), 32'h1);
    chk("R11 vector zero", 32'(msg_vector), 32'h0);
    accept_msg();
    set_pin(13, 1'b0);

    // R12: simultaneous requests leave in ascending order
    cfg_entry(15, 8'hA1, 3'd0, 0, 0, 0, 0, 8'h06);
    cfg_entry(20, 8'hA2, 3'd0, 0, 0, 0, 0, 8'h07);
    @(negedge clk);
    irq_pins[15] = 1'b1; irq_pins[20] = 1'b1;
    wait_msg(8, got); chk("R12 first pin", 32'(msg_pin), 32'd15);
    accept_msg();
    wait_msg(8, got); chk("R12 second pin", 32'(msg_pin), 32'd20);
    accept_msg();
    @(negedge clk);
    irq_pins[15] = 1'b0; irq_pins[20] = 1'b0;

    // R5/R8: random edge requests with random fields
    for (int k = 0; k < 8; k++) begin
      logic [7:0] v, d;
      logic [2:0] dm;
      logic dl;
      int p;
      p  = 16 + k;
      if (p == 20) p = 21;
      v  = 8'($urandom());
      d  = 8'($urandom());
      dl = 1'($urandom());
      case ($urandom_range(2))
        0: dm = 3'd0;
        1: dm = 3'd1;
        default: dm = 3'd7;
      endcase
      cfg_entry(p, v, dm, dl, 0, 0, 0, d);
      set_pin(p, 1'b1);
      wait_msg(8, got);
      chk("R5 random message", 32'(got), 32'h1);
      chk("R8 random vector", 32'(msg_vector), 32'(v));
      chk("R8 random dest", 32'(msg_dest), 32'(d));
      chk("R8 random mode", 32'(msg_dmode), 32'(dm));
      chk("R8 random pin", 32'(msg_pin), 32'(p));
      accept_msg();
      set_pin(p, 1'b0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule